// File: doc/BRIEF.md
# Command Ring Walker

This block consumes host-issued commands from a circular ring kept in system memory. A write to the command doorbell starts a pass. The walker then reads one 16-byte descriptor at a time through a single-beat memory read port. It checks each descriptor's ownership bit against the ring cycle state held in its control register, and it follows link descriptors to jump to another part of the ring. For every descriptor it consumes, it hands a completion event request to a downstream event ring producer over a valid/ready handshake. This block does not interpret the commands themselves. Every consumed descriptor, link descriptors included, completes with a success code.

A pass ends when the walker reaches a descriptor that software does not yet own for the controller, or when a memory read returns an error. When the walker stops on an ownership mismatch, it records the stopping address in the control register so that software and the next pass can see where it stopped. Software loads the control register through a load strobe while the walker is idle. The synchronous reset also acts as the host controller reset.

Top module: `cmdring_walker`

## Requirements
- R1: Reset forces the control register to zero. It also clears the running flag, the event valid output and the memory request.
- R2: A doorbell that arrives while the walker is idle sets the running flag on the next clock edge. The first fetch then starts at the stored dequeue address. After a control-register load, that address is the loaded value with its low 6 bits cleared.
- R3: The descriptor is 128 bits wide. The pointer sits in bits 63:0, the status word in bits 95:64 and the control word in bits 127:96. The descriptor is consumed when control bit 0 (response bit 96) equals control register bit 0.
- R4: On an ownership mismatch the walker stops and clears the running flag. Control register bits 63:6 take the stopping descriptor's address bits 63:6, and bits 5:0 keep their previous value. The next pass resumes at the full 16-byte stopping address.
- R5: The type field is control word bits 15:10. Type 6 (link) makes the next fetch address the descriptor's pointer with its low 6 bits cleared. Any other type advances the fetch address by 16. Every fetch address is 16-byte aligned.
- R6: Each consumed descriptor produces one event. The event pointer is the descriptor address and the status is 0x0100_0000, which is code 1 in bits 31:24. The control word is 0x0000_8401, which is type 33 in bits 15:10 with bit 0 set. The interrupter field is the descriptor's status bits 31:22.
- R7: An event that has not been accepted stays valid and unchanged. No memory request is issued while an event is pending.
- R8: A read error ends the pass with no event. It clears the running flag and leaves the control register unchanged.
- R9: A doorbell that arrives during a pass is remembered. Once the pass stops, exactly one further pass runs from the current dequeue address.
- R10: A control-register load is ignored while a pass is running.
- R11: When a load and a doorbell arrive in the same idle cycle, the new pass uses the loaded address and the loaded cycle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the host controller reset |
| ctl_load | input | 1 | Strobe that loads the control register |
| ctl_load_val | input | ADDR_W | Value to load: ring address and low control bits (bit 0 is the cycle state) |
| doorbell | input | 1 | Command doorbell strobe |
| mem_req | output | 1 | Descriptor read request, held until the response arrives |
| mem_addr | output | ADDR_W | Descriptor address (16-byte aligned) |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 128 | Descriptor contents |
| mem_rsp_err | input | 1 | Read response error |
| ctl_q | output | ADDR_W | Current control register value |
| ring_running | output | 1 | Ring running flag |
| evt_valid | output | 1 | Completion event valid |
| evt_ready | input | 1 | Completion event accepted |
| evt_ptr | output | ADDR_W | Address of the completed descriptor |
| evt_status | output | 32 | Event status word |
| evt_control | output | 32 | Event control word |
| evt_intr | output | 10 | Target interrupter |

## Verification
A control-register load can arrive in the same cycle as the doorbell that starts a pass. The bench drives both strobes on one idle cycle with a ring position and cycle state that differ from the previous ones. It passes only if the first fetched and reported address and the final written-back address come from the new value. A doorbell can also land while a stop is being written back. The bench rings during a held event so that the stop and the stored doorbell meet. It then counts the descriptor fetches: two reads of the stopping address show that the one extra pass ran.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int DESC_W      = 128;
  localparam int OFS_STATUS  = 64;
  localparam int OFS_CONTROL = 96;
  localparam int TYPE_LSB    = 10;
  localparam int TYPE_W      = 6;
  localparam logic [TYPE_W-1:0] TYPE_LINK     = 6'd6;
  localparam logic [TYPE_W-1:0] TYPE_CMD_DONE = 6'd33;
  localparam logic [7:0]        CODE_SUCCESS  = 8'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EVENT = 2'd2
  } walk_state_e;
endpackage

// File: rtl/cmdring_desc_decode.sv
module cmdring_desc_decode
  import cmdring_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 6,
  parameter int DESC_BYTES = 16,
  parameter int INTR_W     = 10
) (
  input  logic [DESC_W-1:0] desc,
  input  logic              ring_cycle,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              cyc_match,
  output logic              is_link,
  output logic [ADDR_W-1:0] next_addr,
  output logic [INTR_W-1:0] tgt_intr
);
  localparam int CTL_TYPE_LO = OFS_CONTROL + TYPE_LSB;

  logic [ADDR_W-1:0] link_tgt;

  assign cyc_match = (desc[OFS_CONTROL] == ring_cycle);
  assign is_link   = (desc[CTL_TYPE_LO +: TYPE_W] == TYPE_LINK);
  assign link_tgt  = {desc[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign next_addr = is_link ? link_tgt : cur_addr + ADDR_W'(DESC_BYTES);
  assign tgt_intr  = desc[OFS_CONTROL-1 -: INTR_W];
endmodule

// File: rtl/cmdring_event_stage.sv
module cmdring_event_stage
  import cmdring_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int INTR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_ptr,
  input  logic [INTR_W-1:0] ld_intr,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] ptr,
  output logic [31:0]       status,
  output logic [31:0]       control,
  output logic [INTR_W-1:0] intr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      ptr   <= '0;
      intr  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      ptr   <= ld_ptr;
      intr  <= ld_intr;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assign status  = {CODE_SUCCESS, 24'h0};
  assign control = {16'h0, TYPE_CMD_DONE, 9'h0, 1'b1};

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(ptr) && $stable(intr))); // R7
endmodule

// File: rtl/cmdring_walker.sv
module cmdring_walker
  import cmdring_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 6,
  parameter int DESC_BYTES = 16,
  parameter int INTR_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_load,
  input  logic [ADDR_W-1:0] ctl_load_val,
  input  logic              doorbell,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic [ADDR_W-1:0] ctl_q,
  output logic              ring_running,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [ADDR_W-1:0] evt_ptr,
  output logic [31:0]       evt_status,
  output logic [31:0]       evt_control,
  output logic [INTR_W-1:0] evt_intr
);
  localparam int DESC_LSB = $clog2(DESC_BYTES);

  walk_state_e       state;
  logic [ADDR_W-1:0] ctl_r, deq_r, fetch_addr, next_q;
  logic              run_r, db_pend;
  logic              cyc_match, is_link;
  logic [ADDR_W-1:0] dec_next;
  logic [INTR_W-1:0] dec_intr;
  logic              rsp_take, evt_load;

  function automatic logic [ADDR_W-1:0] align_ring(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  cmdring_desc_decode #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS),
    .DESC_BYTES(DESC_BYTES), .INTR_W(INTR_W)
  ) u_dec (
    .desc      (mem_rsp_data),
    .ring_cycle(ctl_r[0]),
    .cur_addr  (fetch_addr),
    .cyc_match (cyc_match),
    .is_link   (is_link),
    .next_addr (dec_next),
    .tgt_intr  (dec_intr)
  );

  assign rsp_take = (state == ST_FETCH) && mem_rsp_valid;
  assign evt_load = rsp_take && !mem_rsp_err && cyc_match;

  cmdring_event_stage #(.ADDR_W(ADDR_W), .INTR_W(INTR_W)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .load   (evt_load),
    .ld_ptr (fetch_addr),
    .ld_intr(dec_intr),
    .ready  (evt_ready),
    .valid  (evt_valid),
    .ptr    (evt_ptr),
    .status (evt_status),
    .control(evt_control),
    .intr   (evt_intr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ctl_r      <= '0;
      deq_r      <= '0;
      fetch_addr <= '0;
      next_q     <= '0;
      run_r      <= 1'b0;
      db_pend    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctl_load) begin
            ctl_r <= ctl_load_val;
            deq_r <= align_ring(ctl_load_val);
          end
          if (doorbell || db_pend) begin
            run_r      <= 1'b1;
            db_pend    <= 1'b0;
            state      <= ST_FETCH;
            fetch_addr <= ctl_load ? align_ring(ctl_load_val) : deq_r;
          end
        end
        ST_FETCH: begin
          if (doorbell) db_pend <= 1'b1;
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              run_r <= 1'b0;
              state <= ST_IDLE;
            end else if (!cyc_match) begin
              run_r <= 1'b0;
              ctl_r <= {fetch_addr[ADDR_W-1:ALIGN_BITS], ctl_r[ALIGN_BITS-1:0]};
              deq_r <= fetch_addr;
              state <= ST_IDLE;
            end else begin
              next_q <= dec_next;
              state  <= ST_EVENT;
            end
          end
        end
        ST_EVENT: begin
          if (doorbell) db_pend <= 1'b1;
          if (evt_valid && evt_ready) begin
            fetch_addr <= next_q;
            state      <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req      = (state == ST_FETCH);
  assign mem_addr     = fetch_addr;
  assign ctl_q        = ctl_r;
  assign ring_running = run_r;

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[DESC_LSB-1:0] == '0)); // R5
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> !mem_req); // R7
  AST_DB_STARTS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && doorbell) |=> ring_running); // R2
  AST_STOP_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (rsp_take && !mem_rsp_err && !cyc_match) |=>
      (!ring_running && ctl_q[ADDR_W-1:ALIGN_BITS] == $past(mem_addr[ADDR_W-1:ALIGN_BITS]))); // R4
  AST_ERR_KEEPS_CTL: assert property (@(posedge clk) disable iff (rst)
    (rsp_take && mem_rsp_err) |=> ($stable(ctl_q) && !evt_valid && !ring_running)); // R8
  AST_LOAD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && ctl_load && !rsp_take) |=> $stable(ctl_q)); // R10
endmodule

// File: tb/cmdring_walker_test.sv
module cmdring_walker_test;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_load = 1'b0;
  logic [AW-1:0] ctl_load_val = '0;
  logic          doorbell = 1'b0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          rsp_v = 1'b0;
  logic [127:0]  rsp_d = '0;
  logic          rsp_e = 1'b0;
  logic [AW-1:0] ctl_q;
  logic          ring_running;
  logic          evt_valid;
  logic          ready_i = 1'b1;
  logic [AW-1:0] evt_ptr;
  logic [31:0]   evt_status, evt_control;
  logic [9:0]    evt_intr;

  always #4 clk = ~clk;

  cmdring_walker uut (
    .clk(clk), .rst(rst), .ctl_load(ctl_load), .ctl_load_val(ctl_load_val),
    .doorbell(doorbell), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d), .mem_rsp_err(rsp_e),
    .ctl_q(ctl_q), .ring_running(ring_running), .evt_valid(evt_valid),
    .evt_ready(ready_i), .evt_ptr(evt_ptr), .evt_status(evt_status),
    .evt_control(evt_control), .evt_intr(evt_intr)
  );

  // memory: 16 descriptors at 0x1000..0x10F0, anything else answers with an error
  logic [127:0]  mem [16];
  int            f_n = 0;
  logic [AW-1:0] f_log [64];
  always @(posedge clk) begin
    if (rst) rsp_v <= 1'b0;
    else if (mem_req && !rsp_v) begin
      rsp_v <= 1'b1;
      rsp_e <= (mem_addr[63:8] != 56'h10);
      rsp_d <= mem[mem_addr[7:4]];
      f_log[f_n[5:0]] <= mem_addr;
      f_n <= f_n + 1;
    end else rsp_v <= 1'b0;
  end

  int            ev_n = 0;
  logic [AW-1:0] ev_ptr [64];
  logic [9:0]    ev_intr [64];
  logic [31:0]   ev_st [64];
  logic [31:0]   ev_ct [64];
  always @(posedge clk) begin
    if (!rst && evt_valid && ready_i) begin
      ev_ptr[ev_n[5:0]]  <= evt_ptr;
      ev_intr[ev_n[5:0]] <= evt_intr;
      ev_st[ev_n[5:0]]   <= evt_status;
      ev_ct[ev_n[5:0]]   <= evt_control;
      ev_n <= ev_n + 1;
    end
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input int slot, input logic [5:0] typ,
                                      input logic cyc, input logic [63:0] ptr);
    logic [31:0] st, ct;
    st = (32'(slot + 3) << 22) | 32'h123;
    ct = (32'(typ) << 10) | 32'(cyc);
    return {ct, st, ptr};
  endfunction

  task automatic fill(input int start, input int n, input logic cyc);
    for (int i = 0; i < 16; i++)
      mem[i] = mk(i, 6'd9, (i >= start && i < start + n) ? cyc : ~cyc, 64'h0);
  endtask

  task automatic load_ctl(input logic [AW-1:0] v);
    @(negedge clk); ctl_load = 1'b1; ctl_load_val = v;
    @(negedge clk); ctl_load = 1'b0;
  endtask

  task automatic ring();
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = ring_running ? 0 : quiet + 1;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // start slot, valid count, cycle state (starts 64-byte aligned)
  localparam logic [8:0] VEC [4] = '{
    {4'd0, 4'd3, 1'b1},
    {4'd4, 4'd0, 1'b1},
    {4'd8, 4'd5, 1'b0},
    {4'd4, 4'd10, 1'b1}
  };

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int eb, fb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ctl", ctl_q, 64'h0);
    chk("R1 reset running", 64'(ring_running), 64'h0);
    chk("R1 reset evt_valid", 64'(evt_valid), 64'h0);
    chk("R1 reset mem_req", 64'(mem_req), 64'h0);

    // table-driven walks (R2, R3, R4, R6)
    for (int v = 0; v < 4; v++) begin
      int st, n;
      logic cy;
      logic [AW-1:0] lowv, stop;
      st = int'(VEC[v][8:5]); n = int'(VEC[v][4:1]); cy = VEC[v][0];
      lowv = 64'h2A | 64'(cy);
      fill(st, n, cy);
      load_ctl(64'h1000 + 64'(st * 16) | lowv);
      eb = ev_n;
      @(negedge clk); doorbell = 1'b1;
      @(negedge clk); doorbell = 1'b0;
      chk("R2 running after doorbell", 64'(ring_running), 64'h1);
      wait_idle();
      chk("R3 event count", 64'(ev_n - eb), 64'(n));
      for (int j = 0; j < n; j++) begin
        chk("R6 event ptr", ev_ptr[(eb + j) % 64], 64'h1000 + 64'((st + j) * 16));
        chk("R6 event intr", 64'(ev_intr[(eb + j) % 64]), 64'(st + j + 3));
      end
      if (n > 0) begin
        chk("R6 event status", 64'(ev_st[eb % 64]), 64'h0100_0000);
        chk("R6 event control", 64'(ev_ct[eb % 64]), 64'h0000_8401);
      end
      stop = 64'h1000 + 64'((st + n) * 16);
      chk("R4 stop writeback", ctl_q, (stop & ~64'h3F) | (lowv & 64'h3F));
      chk("R4 running cleared", 64'(ring_running), 64'h0);
    end

    // R5: link descriptor redirect
    fill(16, 0, 1'b1);
    mem[0] = mk(0, 6'd9, 1'b1, 64'h0);
    mem[1] = mk(1, 6'd6, 1'b1, 64'h10A5);
    mem[8] = mk(8, 6'd9, 1'b1, 64'h0);
    load_ctl(64'h1001);
    eb = ev_n;
    ring(); wait_idle();
    chk("R5 link event count", 64'(ev_n - eb), 64'd3);
    chk("R5 link descriptor reported", ev_ptr[(eb + 1) % 64], 64'h1010);
    chk("R5 link target fetched", ev_ptr[(eb + 2) % 64], 64'h1080);
    chk("R5 stop after link", ctl_q, 64'h1081);

    // R8: read error past the populated region
    fill(12, 4, 1'b1);
    load_ctl(64'h10C1);
    eb = ev_n; fb = f_n;
    ring(); wait_idle();
    chk("R8 events before error", 64'(ev_n - eb), 64'd4);
    chk("R8 fetches incl. failing one", 64'(f_n - fb), 64'd5);
    chk("R8 ctl unchanged", ctl_q, 64'h10C1);
    chk("R8 running cleared", 64'(ring_running), 64'h0);

    // R7 and R10: back-pressure holds the event; load while busy is ignored
    fill(0, 2, 1'b1);
    load_ctl(64'h1001);
    eb = ev_n; fb = f_n;
    ready_i = 1'b0;
    ring();
    repeat (10) @(negedge clk);
    chk("R7 event held valid", 64'(evt_valid), 64'h1);
    chk("R7 held event ptr", evt_ptr, 64'h1000);
    chk("R7 no further fetch", 64'(f_n - fb), 64'd1);
    load_ctl(64'h2000_0000);
    ready_i = 1'b1;
    wait_idle();
    chk("R7 events after release", 64'(ev_n - eb), 64'd2);
    chk("R10 busy load ignored", ctl_q, 64'h1001);

    // R9: doorbell during a pass gives one more pass from the stop address
    fill(0, 1, 1'b1);
    load_ctl(64'h1001);
    eb = ev_n; fb = f_n;
    ready_i = 1'b0;
    ring();
    repeat (5) @(negedge clk);
    ring();
    ready_i = 1'b1;
    wait_idle();
    chk("R9 fetch count with rerun", 64'(f_n - fb), 64'd3);
    chk("R9 rerun address", f_log[(f_n - 1) % 64], 64'h1010);
    chk("R9 single event", 64'(ev_n - eb), 64'd1);

    // R11: load and doorbell in the same idle cycle
    fill(4, 2, 1'b0);
    eb = ev_n;
    @(negedge clk); ctl_load = 1'b1; ctl_load_val = 64'h1040; doorbell = 1'b1;
    @(negedge clk); ctl_load = 1'b0; doorbell = 1'b0;
    wait_idle();
    chk("R11 event count", 64'(ev_n - eb), 64'd2);
    chk("R11 first ptr from loaded value", ev_ptr[eb % 64], 64'h1040);
    chk("R11 writeback keeps loaded cycle", ctl_q, 64'h1040);

    // R1: reset in the middle of a pass
    fill(0, 2, 1'b1);
    load_ctl(64'h1001);
    ready_i = 1'b0;
    ring();
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid-walk reset ctl", ctl_q, 64'h0);
    chk("R1 mid-walk reset running", 64'(ring_running), 64'h0);
    chk("R1 mid-walk reset evt_valid", 64'(evt_valid), 64'h0);
    chk("R1 mid-walk reset mem_req", 64'(mem_req), 64'h0);
    rst = 1'b0;
    ready_i = 1'b1;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end
endmodule